// File: doc/BRIEF.md
# Decoupled Receive Buffer Ring Engine

This engine sits on the receive path of a multi-core network interface. Each core owns two rings that work apart from each other. The allocation ring is a small circular store of empty-buffer pointers that software posts through a doorbell port. The reception ring is a larger circular store of arrival notifications that software drains by moving its head pointer. When a packet arrives tagged with a destination core, the engine takes one free pointer and writes a notification into the destination core's reception ring. The pointer comes from that core's own allocation ring if it holds one, and otherwise from another core's ring. The notification carries the pointer, the packet length, the ring the pointer came from and a phase bit.

The engine arbitrates all sharing of buffers between cores. Software therefore posts buffers and drains notifications with no lock, and a core that stops reposting cannot starve the other cores while any allocation ring still holds a pointer. A packet that finds no buffer anywhere, or that finds its reception ring full, is dropped and counted per destination core. A drop caused by a full reception ring leaves every allocation ring untouched.

Top module: `rxsplit_engine`

## Requirements
- R1: After reset every allocation ring and reception ring is empty, all drop counters read zero, `poll_data` reads zero, and the borrow pointer is set so that the first borrow scan starts at core 0.
- R2: A doorbell (`post_valid` with `post_core`, `post_buf`) appends the pointer at the tail of that core's allocation ring. If the ring already holds ALLOC_DEPTH pointers, the doorbell is ignored and the pointer is never handed out. A pointer posted in the same cycle as a packet is presented can serve that packet. A pointer posted one cycle later cannot.
- R3: Each allocation ring hands out its pointers in the order they were posted, and an empty ring is never popped.
- R4: When the destination core's own allocation ring is non-empty, the pointer is taken from it.
- R5: When the own ring is empty, the engine scans the other cores round-robin. The scan starts at the core after the last core borrowed from and takes the first non-empty ring. Only a borrow moves the borrow pointer.
- R6: A notification is written at the tail of the destination core's reception ring. Its bit fields are: buffer pointer in [BUF_W-1:0], length in [BUF_W+LEN_W-1:BUF_W], source ring index in the next CORE_W bits, and a phase bit in the MSB. The phase bit is 1 on the first pass through the ring and inverts on every wrap.
- R7: Each accepted packet pops exactly one pointer and writes exactly one notification. Both happen on the second rising edge after the packet is presented, and the drop counters change on that same edge.
- R8: If the reception ring has room but every allocation ring is empty, the packet is dropped and `nobuf_cnt` of its destination core increments by one.
- R9: If the destination reception ring holds RECV_DEPTH entries, the packet is dropped, no pointer is consumed, nothing is written, and `full_cnt` of that core increments by one. This check takes priority over R8.
- R10: Writing `head_val` (index plus one wrap bit) for a core sets its software head. Occupancy is tail minus head, so the ring counts as full at exactly RECV_DEPTH entries, and writing the head frees slots for packets selected in later cycles.
- R11: A new packet may be presented on every clock, and each packet sees the ring state left by the one before it.
- R12: `poll_data` returns, one cycle after `poll_core` and `poll_idx` are presented, the entry that the slot held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet arrival this cycle |
| pkt_core | input | CORE_W | Destination core of the packet |
| pkt_len | input | LEN_W | Packet length |
| post_valid | input | 1 | Allocation doorbell write |
| post_core | input | CORE_W | Core whose allocation ring receives the pointer |
| post_buf | input | BUF_W | Empty buffer pointer |
| head_wr | input | 1 | Software reception head update |
| head_core | input | CORE_W | Core whose reception head is written |
| head_val | input | RIDX_W+1 | New head index with wrap bit |
| poll_core | input | CORE_W | Core whose reception ring is read |
| poll_idx | input | RIDX_W | Slot read from that ring |
| poll_data | output | NOTE_W | Registered notification read |
| nobuf_cnt | output | NUM_CORES*CNT_W | Per-core no-buffer drop counters, core c at bits c*CNT_W |
| full_cnt | output | NUM_CORES*CNT_W | Per-core ring-full drop counters, core c at bits c*CNT_W |

## Verification
Two functions can fall in the same cycle on one ring: a doorbell append can coincide with the pointer selection for a packet, and a software head write can coincide with the full test on that same reception ring. The bench provokes the first case in both alignments. In one, the packet and the doorbell are presented together into an otherwise empty pool, so the packet must receive the new pointer. In the other, the doorbell comes one cycle after the packet, so the packet must be counted as a no-buffer drop and the pointer must serve the next packet. A long random phase mixes packets, doorbells and head writes on every cycle. A behavioural queue model updated on each edge judges the counters and the polled notifications on every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   typedef enum logic [1:0] {
      SRC_OWN    = 2'd0,
      SRC_BORROW = 2'd1,
      SRC_NONE   = 2'd2
   } src_kind_e;

   function automatic int clog2_min1(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/rxs_alloc_ring.sv
module rxs_alloc_ring #(
   parameter int DEPTH = 256,
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PTR_W-1:0] push_ptr,
   input  logic             pop,
   output logic             empty,
   output logic [PTR_W-1:0] head_ptr
);
   localparam int IW = $clog2(DEPTH);

   logic [IW:0]      wp_q, rp_q;
   logic [PTR_W-1:0] mem [DEPTH];
   logic             full;
   logic             do_push, do_pop;

   assign empty    = (wp_q == rp_q);
   assign full     = (wp_q[IW] != rp_q[IW]) && (wp_q[IW-1:0] == rp_q[IW-1:0]);
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign head_ptr = mem[rp_q[IW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q[IW-1:0]] <= push_ptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
      end
   end
endmodule

// File: rtl/rxs_recv_ring.sv
module rxs_recv_ring #(
   parameter int DEPTH  = 512,
   parameter int NOTE_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [NOTE_W-2:0] wr_body,
   input  logic              head_wr,
   input  logic [$clog2(DEPTH):0]   head_val,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [NOTE_W-1:0] rd_note,
   output logic              full
);
   localparam int IW = $clog2(DEPTH);

   logic [IW:0]       wp_q, hd_q, occ;
   logic [NOTE_W-1:0] mem [DEPTH];

   // occupancy never exceeds DEPTH, so its top bit marks a full ring
   assign occ     = wp_q - hd_q;
   assign full    = occ[IW];
   assign rd_note = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (wr && !full) mem[wp_q[IW-1:0]] <= {~wp_q[IW], wr_body};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         hd_q <= '0;
      end else begin
         if (wr && !full) wp_q <= wp_q + 1'b1;
         if (head_wr)     hd_q <= head_val;
      end
   end
endmodule

// File: rtl/rxs_src_select.sv
module rxs_src_select import rxs_pkg::*; #(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input  logic [CW-1:0] dest,
   input  logic [N-1:0]  avail,
   input  logic [CW-1:0] last,
   output src_kind_e     kind,
   output logic [CW-1:0] src
);
   localparam bit IS_POW2 = ((N & (N - 1)) == 0);

   function automatic logic [CW-1:0] step(input logic [CW-1:0] base, input int k);
      if (IS_POW2) return base + CW'(k);
      else         return CW'((int'(base) + k) % N);
   endfunction

   always_comb begin
      kind = SRC_NONE;
      src  = dest;
      if (avail[dest]) begin
         kind = SRC_OWN;
      end else begin
         for (int k = 1; k <= N; k++) begin
            if (kind == SRC_NONE && step(last, k) != dest && avail[step(last, k)]) begin
               kind = SRC_BORROW;
               src  = step(last, k);
            end
         end
      end
   end
endmodule

// File: rtl/rxsplit_engine.sv
module rxsplit_engine import rxs_pkg::*; #(
   parameter int NUM_CORES   = 4,
   parameter int ALLOC_DEPTH = 256,
   parameter int RECV_DEPTH  = 512,
   parameter int BUF_W       = 32,
   parameter int LEN_W       = 14,
   parameter int CNT_W       = 16,
   localparam int CORE_W = clog2_min1(NUM_CORES),
   localparam int RIDX_W = $clog2(RECV_DEPTH),
   localparam int NOTE_W = 1 + CORE_W + LEN_W + BUF_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pkt_valid,
   input  logic [CORE_W-1:0]          pkt_core,
   input  logic [LEN_W-1:0]           pkt_len,
   input  logic                       post_valid,
   input  logic [CORE_W-1:0]          post_core,
   input  logic [BUF_W-1:0]           post_buf,
   input  logic                       head_wr,
   input  logic [CORE_W-1:0]          head_core,
   input  logic [RIDX_W:0]            head_val,
   input  logic [CORE_W-1:0]          poll_core,
   input  logic [RIDX_W-1:0]          poll_idx,
   output logic [NOTE_W-1:0]          poll_data,
   output logic [NUM_CORES*CNT_W-1:0] nobuf_cnt,
   output logic [NUM_CORES*CNT_W-1:0] full_cnt
);
   // elaboration-time parameter checks
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("NUM_CORES must be at least 2");
   end
   if (ALLOC_DEPTH < 2 || (ALLOC_DEPTH & (ALLOC_DEPTH - 1)) != 0) begin : g_bad_adepth
      $error("ALLOC_DEPTH must be a power of two, at least 2");
   end
   if (RECV_DEPTH < ALLOC_DEPTH || (RECV_DEPTH & (RECV_DEPTH - 1)) != 0) begin : g_bad_rdepth
      $error("RECV_DEPTH must be a power of two, not below ALLOC_DEPTH");
   end
   if (CNT_W < 1 || LEN_W < 1 || BUF_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   // stage register: packet accepted this cycle, served next edge
   logic              s_vld;
   logic [CORE_W-1:0] s_core;
   logic [LEN_W-1:0]  s_len;

   logic [NUM_CORES-1:0] a_empty, a_pop, rx_full, rx_wr;
   logic [BUF_W-1:0]     a_head_ptr [NUM_CORES];
   logic [NOTE_W-1:0]    rx_note    [NUM_CORES];

   src_kind_e         sel_kind;
   logic [CORE_W-1:0] sel_src;
   logic [CORE_W-1:0] last_q;
   logic              consume;
   logic              dest_full;
   logic [NOTE_W-2:0] body;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld  <= 1'b0;
         s_core <= '0;
         s_len  <= '0;
      end else begin
         s_vld  <= pkt_valid;
         s_core <= pkt_core;
         s_len  <= pkt_len;
      end
   end

   rxs_src_select #(.N(NUM_CORES), .CW(CORE_W)) u_sel (
      .dest  (s_core),
      .avail (~a_empty),
      .last  (last_q),
      .kind  (sel_kind),
      .src   (sel_src)
   );

   assign dest_full = rx_full[s_core];
   assign consume   = s_vld && !dest_full && (sel_kind != SRC_NONE);
   assign body      = {sel_src, s_len, a_head_ptr[sel_src]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             last_q <= CORE_W'(NUM_CORES - 1);
      else if (consume && sel_kind == SRC_BORROW) last_q <= sel_src;
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [CNT_W-1:0] nb_q, fu_q;

      assign a_pop[c] = consume && (sel_src == CORE_W'(c));
      assign rx_wr[c] = consume && (s_core == CORE_W'(c));

      rxs_alloc_ring #(.DEPTH(ALLOC_DEPTH), .PTR_W(BUF_W)) u_alloc (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (post_valid && post_core == CORE_W'(c)),
         .push_ptr (post_buf),
         .pop      (a_pop[c]),
         .empty    (a_empty[c]),
         .head_ptr (a_head_ptr[c])
      );

      rxs_recv_ring #(.DEPTH(RECV_DEPTH), .NOTE_W(NOTE_W)) u_recv (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (rx_wr[c]),
         .wr_body  (body),
         .head_wr  (head_wr && head_core == CORE_W'(c)),
         .head_val (head_val),
         .rd_idx   (poll_idx),
         .rd_note  (rx_note[c]),
         .full     (rx_full[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nb_q <= '0;
            fu_q <= '0;
         end else if (s_vld && s_core == CORE_W'(c)) begin
            if (rx_full[c])                nb_q <= nb_q;
            else if (sel_kind == SRC_NONE) nb_q <= nb_q + 1'b1;
            if (rx_full[c])                fu_q <= fu_q + 1'b1;
         end
      end

      assign nobuf_cnt[c*CNT_W +: CNT_W] = nb_q;
      assign full_cnt[c*CNT_W +: CNT_W]  = fu_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) poll_data <= '0;
      else        poll_data <= rx_note[poll_core];
   end
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          s_vld,
   input logic [CW-1:0] s_core,
   input logic [N-1:0]  a_empty,
   input logic [N-1:0]  a_pop,
   input logic [N-1:0]  rx_full,
   input logic [N-1:0]  rx_wr
);
   // R4
   own_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && !rx_full[s_core] && !a_empty[s_core] |-> a_pop[s_core]);

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_vld && rx_full[s_core] |-> (a_pop == '0) && (rx_wr == '0));

   // R3
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_pop & a_empty) == '0);

   // R7
   pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(a_pop) == $countones(rx_wr));

   // R7
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_vld |-> (a_pop == '0) && (rx_wr == '0));

   // R11
   single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(a_pop) && $onehot0(rx_wr));

   // R6
   dest_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |rx_wr |-> rx_wr[s_core] && !rx_full[s_core]);
endmodule

bind rxsplit_engine rxs_chk #(.N(NUM_CORES), .CW(CORE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_vld   (s_vld),
   .s_core  (s_core),
   .a_empty (a_empty),
   .a_pop   (a_pop),
   .rx_full (rx_full),
   .rx_wr   (rx_wr)
);

// File: tb/sim_rxsplit_engine.sv
`timescale 1ns/1ps
module sim_rxsplit_engine;
   localparam int NC = 4, AD = 4, RD = 8, BW = 16, LW = 12, CNTW = 16;
   localparam int CW = 2, RW = 3, NW = 1 + CW + LW + BW;

   logic clk = 0, rst_n = 0;
   logic pkt_valid = 0, post_valid = 0, head_wr = 0;
   logic [CW-1:0] pkt_core = 0, post_core = 0, head_core = 0, poll_core = 0;
   logic [LW-1:0] pkt_len = 0;
   logic [BW-1:0] post_buf = 0;
   logic [RW:0]   head_val = 0;
   logic [RW-1:0] poll_idx = 0;
   logic [NW-1:0] poll_data;
   logic [NC*CNTW-1:0] nobuf_cnt, full_cnt;

   always #2.5 clk = ~clk;

   rxsplit_engine #(.NUM_CORES(NC), .ALLOC_DEPTH(AD), .RECV_DEPTH(RD),
                    .BUF_W(BW), .LEN_W(LW), .CNT_W(CNTW)) u0 (.*);

   int nchk = 0, nerr = 0, cyc = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] mk(input int ph, input int src, input int len, input int ptr);
      return {1'(ph), CW'(src), LW'(len), BW'(ptr)};
   endfunction

   // ---------------- behavioural reference model ----------------
   logic [BW-1:0] abuf [NC][AD];
   int ahd [NC], atl [NC], acnt [NC];
   logic [NW-1:0] rmem [NC][RD];
   bit  rval [NC][RD];
   int  rwp [NC], rhd [NC], ncnt [NC], fcnt [NC];
   int  mlast;
   bit  m_sv; int m_sc, m_sl;
   logic [NW-1:0] ep; bit ep_known;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NC; c++) begin
            ahd[c] = 0; atl[c] = 0; acnt[c] = 0; rwp[c] = 0; rhd[c] = 0;
            ncnt[c] = 0; fcnt[c] = 0;
            for (int i = 0; i < RD; i++) rval[c][i] = 0;
         end
         mlast = NC - 1; m_sv = 0; ep = '0; ep_known = 1;
      end else begin
         int pre_post_cnt, occ, src, slot;
         ep_known = rval[poll_core][poll_idx];
         ep = rmem[poll_core][poll_idx];
         pre_post_cnt = acnt[post_core];
         if (m_sv) begin
            occ = (rwp[m_sc] - rhd[m_sc] + 2*RD) % (2*RD);
            if (occ == RD) fcnt[m_sc]++;
            else begin
               src = -1;
               if (acnt[m_sc] > 0) src = m_sc;
               else for (int k = 1; k <= NC; k++)
                  if (src < 0 && acnt[(mlast + k) % NC] > 0) src = (mlast + k) % NC;
               if (src < 0) ncnt[m_sc]++;
               else begin
                  slot = rwp[m_sc] % RD;
                  rmem[m_sc][slot] = mk((rwp[m_sc] < RD) ? 1 : 0, src, m_sl, int'(abuf[src][ahd[src]]));
                  rval[m_sc][slot] = 1;
                  rwp[m_sc] = (rwp[m_sc] + 1) % (2*RD);
                  ahd[src] = (ahd[src] + 1) % AD; acnt[src]--;
                  if (src != m_sc) mlast = src;
               end
            end
         end
         if (post_valid && pre_post_cnt < AD) begin
            abuf[post_core][atl[post_core]] = post_buf;
            atl[post_core] = (atl[post_core] + 1) % AD; acnt[post_core]++;
         end
         if (head_wr) rhd[head_core] = int'(head_val);
         m_sv = pkt_valid; m_sc = int'(pkt_core); m_sl = int'(pkt_len);
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NC; c++) begin
            chk("R8 nobuf counter", 64'(nobuf_cnt[c*CNTW +: CNTW]), 64'(CNTW'(ncnt[c])));
            chk("R9 full counter", 64'(full_cnt[c*CNTW +: CNTW]), 64'(CNTW'(fcnt[c])));
         end
         if (ep_known) chk("R6 R12 polled notification", 64'(poll_data), 64'(ep));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nerr++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic send(input int c, input int l);
      pkt_valid = 1; pkt_core = CW'(c); pkt_len = LW'(l);
      @(negedge clk); pkt_valid = 0;
   endtask
   task automatic post(input int c, input int b);
      post_valid = 1; post_core = CW'(c); post_buf = BW'(b);
      @(negedge clk); post_valid = 0;
   endtask
   task automatic both(input int c, input int l, input int pc, input int b);
      pkt_valid = 1; pkt_core = CW'(c); pkt_len = LW'(l);
      post_valid = 1; post_core = CW'(pc); post_buf = BW'(b);
      @(negedge clk); pkt_valid = 0; post_valid = 0;
   endtask
   task automatic sethead(input int c, input int v);
      head_wr = 1; head_core = CW'(c); head_val = (RW+1)'(v);
      @(negedge clk); head_wr = 0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic poll_expect(input string req, input int c, input int i, input logic [NW-1:0] exp);
      poll_core = CW'(c); poll_idx = RW'(i);
      @(negedge clk);
      chk(req, 64'(poll_data), 64'(exp));
   endtask

   initial begin
      idle(3);
      // R1: reset state
      chk("R1 poll_data after reset", 64'(poll_data), 64'(0));
      chk("R1 nobuf_cnt after reset", 64'(nobuf_cnt), 64'(0));
      chk("R1 full_cnt after reset", 64'(full_cnt), 64'(0));
      rst_n = 1;
      idle(1);
      // R8: nothing posted yet
      send(1, 50); idle(2);
      chk("R8 drop with empty pool", 64'(nobuf_cnt[1*CNTW +: CNTW]), 64'(1));

      // R2: fill core 0, overflow post is ignored
      for (int i = 0; i < 4; i++) post(0, 'h100 + i);
      post(0, 'h1FF);
      post(2, 'h200); post(2, 'h201);
      // R4 R3: own ring, FIFO order
      send(0, 64); send(0, 65);
      // R5: borrow round-robin from core 0, then 2, then 0 again
      send(1, 66); send(1, 67); send(1, 68);
      idle(3);
      poll_expect("R4 own ring first", 0, 0, mk(1, 0, 64, 'h100));
      poll_expect("R3 posting order", 0, 1, mk(1, 0, 65, 'h101));
      poll_expect("R5 first borrow", 1, 0, mk(1, 0, 66, 'h102));
      poll_expect("R5 round-robin next", 1, 1, mk(1, 2, 67, 'h200));
      poll_expect("R5 wrap of scan", 1, 2, mk(1, 0, 68, 'h103));

      // R11 R9 R10: back-to-back fill of core 3's reception ring
      for (int i = 0; i < 4; i++) post(3, 'h300 + i);
      for (int i = 0; i < 4; i++) post(0, 'h104 + i);
      for (int i = 0; i < 8; i++) send(3, 90 + i);
      send(3, 98);
      idle(3);
      chk("R9 ring-full drop", 64'(full_cnt[3*CNTW +: CNTW]), 64'(1));
      poll_expect("R11 back-to-back borrow", 3, 4, mk(1, 2, 94, 'h201));
      sethead(3, 2);
      send(3, 99);
      idle(3);
      poll_expect("R10 R6 slot freed, phase inverted", 3, 0, mk(0, 0, 99, 'h107));
      send(3, 100); idle(2);
      chk("R2 overflow pointer never used", 64'(nobuf_cnt[3*CNTW +: CNTW]), 64'(1));

      // R2: doorbell and selection in the same cycle
      both(2, 80, 2, 'h2AA);
      send(1, 81); post(1, 'h1AA);
      send(1, 82);
      idle(3);
      poll_expect("R2 same-cycle post served", 2, 0, mk(1, 2, 80, 'h2AA));
      chk("R2 late post misses packet", 64'(nobuf_cnt[1*CNTW +: CNTW]), 64'(2));
      poll_expect("R2 late post kept", 1, 3, mk(1, 1, 82, 'h1AA));

      // random mix; the model judges every clock (R7 timing included)
      for (int n = 0; n < 3000; n++) begin
         int c;
         pkt_valid  = ($urandom % 3) != 0;
         pkt_core   = CW'($urandom);
         pkt_len    = LW'($urandom);
         post_valid = ($urandom % 2) != 0;
         post_core  = CW'($urandom);
         post_buf   = BW'($urandom);
         c = $urandom % NC;
         head_wr    = ($urandom % 4) == 0;
         head_core  = CW'(c);
         head_val   = (RW+1)'(($urandom % 2) ? rwp[c] : (rhd[c] + ((rwp[c] != rhd[c]) ? 1 : 0)) % (2*RD));
         poll_core  = CW'(n % NC);
         poll_idx   = RW'(n / NC);
         @(negedge clk);
      end
      pkt_valid = 0; post_valid = 0; head_wr = 0;
      idle(4);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule